// File: doc/BRIEF.md
# Three-Digit Sequential Combination Lock

This block is a clocked door lock that releases only after a fixed three-digit code has been entered in order. The user presents a value on the input bus and marks it with a single-cycle strobe; every strobed value is compared against the digit expected at the current step. The three stored digits are fixed by parameters, and the default code is 3, then 4, then 2. A strobed value that matches moves the lock one step forward. The door output goes high after the third match.

A strobed value that does not match sends the lock into a trapped error state. The lock does not say at which step the mistake happened, and it accepts no further digits until it is reset. The open state is also trapped and leaves only on reset.

The datapath holds the stored digits, a one-hot selector that picks the digit for the current step, and one equality comparator. A small state machine drives that datapath. The state encoding is chosen so that the lower three state bits form the selector and the top bit is the door output, so neither output needs decode logic. A two-bit step index is brought out for observation.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the lock returns to its first step, whatever `val_stb` and `val_in` carry: after that edge `door_open`=0 and `step_idx`=0.
- R2: In steps 0, 1 and 2, a clock edge with `val_stb` low leaves `step_idx` and `door_open` unchanged, whatever `val_in` carries.
- R3: In step 0, 1 or 2, a strobed value equal to that step's stored digit raises `step_idx` by one after the edge.
- R4: With the default code, strobing 3, then 4, then 2 sets `door_open`=1 right after the edge that takes the third strobe. Idle cycles between the strobes make no difference.
- R5: In step 0, 1 or 2, a strobed value that differs from that step's digit moves the lock to the error state. The error state shows `door_open`=0 and `step_idx`=3.
- R6: Once open, the lock stays open (`door_open`=1, `step_idx`=3) through any further strobes, until reset.
- R7: The error state holds `door_open`=0 and `step_idx`=3 through any further strobes, including the correct digits, until reset.
- R8: `door_open` is 1 only in the open state. It is 0 in steps 0 to 2 and in the error state.
- R9: `step_idx` reads 0, 1 and 2 while the lock waits for the first, second and third digit, and reads 3 in both the open and the error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to the first step |
| val_in | input | VAL_W (4) | Entered code value |
| val_stb | input | 1 | Marks `val_in` as a new entry for one cycle |
| door_open | output | 1 | High only while the lock is open |
| step_idx | output | 2 | Current step: 0 to 2 while entering, 3 when open or in error |

## Verification
The properties assume that the reset is held high from time zero through the first rising edge, so the state is defined before any check is enabled. They also assume that `val_stb` and `val_in` change only away from the rising edge. The bench drives every input on the falling edge, keeps the reset high through the first edges, and drops `val_stb` after a single cycle. The properties on the step index treat `step_idx`=3 with `door_open`=0 as the error state, which holds only if the error state and the open state are the only states that report step 3.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

    localparam int NUM_STEPS = 3;
    localparam int STATE_W   = NUM_STEPS + 1;
    localparam int IDX_W     = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_ERR   = 4'b0000,
        ST_STEP0 = 4'b0001,
        ST_STEP1 = 4'b0010,
        ST_STEP2 = 4'b0100,
        ST_OPEN  = 4'b1000
    } lock_state_e;

    typedef logic [NUM_STEPS-1:0] digit_sel_t;

    function automatic logic [IDX_W-1:0] step_of(input lock_state_e s);
        logic [IDX_W-1:0] idx;
        case (s)
            ST_STEP0: idx = 2'd0;
            ST_STEP1: idx = 2'd1;
            ST_STEP2: idx = 2'd2;
            default:  idx = 2'd3;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/combo_lock_digit_path.sv
module combo_lock_digit_path
    import combo_lock_pkg::*;
#(
    parameter int VAL_W = 4,
    parameter logic [NUM_STEPS*VAL_W-1:0] CODE = '0
) (
    input  digit_sel_t       sel,
    input  logic [VAL_W-1:0] val_in,
    output logic             match
);
    logic [VAL_W-1:0] masked [NUM_STEPS];
    logic [VAL_W-1:0] picked;

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_digit
        assign masked[g] = sel[g] ? CODE[g*VAL_W +: VAL_W] : '0;
    end

    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_STEPS; i++) begin
            picked = picked | masked[i];
        end
    end

    assign match = (val_in == picked);
endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
    import combo_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        val_stb,
    input  logic        match,
    output lock_state_e state_q
);
    lock_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_STEP0, ST_STEP1, ST_STEP2: begin
                if (val_stb) begin
                    // one-hot advance is a left shift of the state
                    state_d = match ? lock_state_e'(state_q << 1) : ST_ERR;
                end
            end
            ST_OPEN: state_d = ST_OPEN;
            ST_ERR:  state_d = ST_ERR;
            default: state_d = ST_STEP0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_STEP0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import combo_lock_pkg::*;
#(
    parameter int VAL_W  = 4,
    parameter int CODE_1 = 3,
    parameter int CODE_2 = 4,
    parameter int CODE_3 = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] val_in,
    input  logic             val_stb,
    output logic             door_open,
    output logic [1:0]       step_idx
);
    localparam logic [NUM_STEPS*VAL_W-1:0] CODE =
        {CODE_3[VAL_W-1:0], CODE_2[VAL_W-1:0], CODE_1[VAL_W-1:0]};

    lock_state_e state_q;
    digit_sel_t  digit_sel;
    logic        match;

    assign digit_sel = state_q[NUM_STEPS-1:0];
    assign door_open = state_q[STATE_W-1];
    assign step_idx  = step_of(state_q);

    combo_lock_digit_path #(
        .VAL_W (VAL_W),
        .CODE  (CODE)
    ) u_path (
        .sel    (digit_sel),
        .val_in (val_in),
        .match  (match)
    );

    combo_lock_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .val_stb (val_stb),
        .match   (match),
        .state_q (state_q)
    );
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk #(
    parameter int VAL_W  = 4,
    parameter int CODE_1 = 3,
    parameter int CODE_2 = 4,
    parameter int CODE_3 = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [VAL_W-1:0] val_in,
    input logic             val_stb,
    input logic             door_open,
    input logic [1:0]       step_idx,
    input logic [2:0]       digit_sel
);
    logic [VAL_W-1:0] want;
    always_comb begin
        case (step_idx)
            2'd0:    want = CODE_1[VAL_W-1:0];
            2'd1:    want = CODE_2[VAL_W-1:0];
            default: want = CODE_3[VAL_W-1:0];
        endcase
    end

    // reset itself is the trigger here, so it cannot gate this property
    a_r1_reset_to_first: assert property (@(posedge clk)
        rst |=> (step_idx == 2'd0 && !door_open));

    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        (!val_stb && step_idx != 2'd3) |=> ($stable(step_idx) && $stable(door_open)));

    a_r3_match_advances: assert property (@(posedge clk) disable iff (rst)
        (val_stb && step_idx != 2'd3 && val_in == want)
            |=> (step_idx == $past(step_idx) + 2'd1));

    a_r5_mismatch_to_err: assert property (@(posedge clk) disable iff (rst)
        (val_stb && step_idx != 2'd3 && val_in != want)
            |=> (step_idx == 2'd3 && !door_open));

    a_r6_open_absorbing: assert property (@(posedge clk) disable iff (rst)
        door_open |=> door_open);

    a_r7_err_absorbing: assert property (@(posedge clk) disable iff (rst)
        (step_idx == 2'd3 && !door_open) |=> (step_idx == 2'd3 && !door_open));

    a_r8_open_only_at_end: assert property (@(posedge clk) disable iff (rst)
        door_open |-> step_idx == 2'd3);

    a_r9_select_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(digit_sel) && ((step_idx == 2'd3) == (digit_sel == 3'b000)));
endmodule

bind combo_lock combo_lock_chk #(
    .VAL_W  (VAL_W),
    .CODE_1 (CODE_1),
    .CODE_2 (CODE_2),
    .CODE_3 (CODE_3)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .val_in    (val_in),
    .val_stb   (val_stb),
    .door_open (door_open),
    .step_idx  (step_idx),
    .digit_sel (digit_sel)
);

// File: tb/sim_combo_lock.sv
`timescale 1ns/1ps
module sim_combo_lock;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] val_in = 4'd0;
    logic       val_stb = 1'b0;
    logic       door_open;
    logic [1:0] step_idx;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    combo_lock u0 (
        .clk       (clk),
        .rst       (rst),
        .val_in    (val_in),
        .val_stb   (val_stb),
        .door_open (door_open),
        .step_idx  (step_idx)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_state(input string req, input int exp_step, input int exp_open);
        check({req, " step_idx"}, int'(step_idx), exp_step);
        check({req, " door_open"}, int'(door_open), exp_open);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        val_stb = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic strobe(input logic [3:0] v);
        @(negedge clk);
        val_in = v;
        val_stb = 1'b1;
        @(negedge clk);
        val_stb = 1'b0;
        val_in = 4'hF;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            val_in = 4'(i + 5);
        end
    endtask

    task automatic t_reset_state();
        // R1: strobe the right first digit while reset is high
        @(negedge clk);
        rst = 1'b1;
        val_in = 4'd3;
        val_stb = 1'b1;
        @(negedge clk);
        check_state("R1 reset with strobe", 0, 0);
        val_stb = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_state("R1 after release", 0, 0);
    endtask

    task automatic t_good_seq_with_gaps();
        do_reset();
        strobe(4'd3);
        check_state("R3 first digit", 1, 0);
        check_state("R9 step after first", 1, 0);
        idle(3);
        check_state("R2 hold during gap", 1, 0);
        strobe(4'd4);
        check_state("R3 second digit", 2, 0);
        idle(2);
        check_state("R2 hold before third", 2, 0);
        strobe(4'd2);
        check_state("R4 opens on third", 3, 1);
    endtask

    task automatic t_wrong_at(input int pos);
        do_reset();
        if (pos >= 1) strobe(4'd3);
        if (pos >= 2) strobe(4'd4);
        check_state("R8 closed before error", pos, 0);
        strobe(4'd9);
        check_state($sformatf("R5 wrong digit at %0d", pos), 3, 0);
    endtask

    task automatic t_extra_in_open();
        do_reset();
        strobe(4'd3);
        strobe(4'd4);
        strobe(4'd2);
        strobe(4'd7);
        check_state("R6 open after wrong extra", 3, 1);
        strobe(4'd3);
        check_state("R6 open after right extra", 3, 1);
        do_reset();
        check_state("R1 reset from open", 0, 0);
    endtask

    task automatic t_extra_in_err();
        do_reset();
        strobe(4'd3);
        strobe(4'd1);
        strobe(4'd3);
        strobe(4'd4);
        strobe(4'd2);
        check_state("R7 err keeps closed", 3, 0);
        do_reset();
        check_state("R1 reset from err", 0, 0);
        strobe(4'd3);
        strobe(4'd4);
        do_reset();
        check_state("R1 reset from third step", 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_good_seq_with_gaps();
        for (int p = 0; p < 3; p++) t_wrong_at(p);
        t_extra_in_open();
        t_extra_in_err();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule